// File: doc/BRIEF.md
# Quadrature Encoder Position Counter

The block turns the two phase signals and the index signal of an incremental shaft encoder into a signed-direction position count of `CNT_W` bits (16 by default). A three-bit mode field sets how phase edges are counted. In x4 decoding every edge of either phase counts. In x2 decoding only phase A edges count. The mode field also sets how the count returns to its starting point: at a programmable maximum count, or on each rising edge of the index signal. One further mode stops decoding and turns the counter into a free-running timer that steps once per clock.

Software reaches the block through a small register port. Writes are synchronous and reads are combinational. The port gives access to a control word, the live count and the maximum count. The control word also reports the count direction, the synchronized index level and a sticky error flag. That flag is set when an index edge arrives while the count is not at the value expected at a revolution boundary. A swap bit exchanges the two phase inputs before decoding. An enable bit drives the count direction onto a dedicated output pin.

Top module: `qenc_counter`

## Requirements
- R1: After reset, the control word, the count and the maximum count all read 0, and `dir_o` and `dir_oe_o` are 0.
- R2: Modes 3'b111 and 3'b110 (x4) count one step on each edge of either synchronized phase. The count goes up when phase A leads, which is the (A,B) order 00→10→11→01→00. The count goes down in the reverse order.
- R3: Modes 3'b101 and 3'b100 (x2) count only on phase A edges. The step is up when A differs from B after the edge and down otherwise. Phase B edges alone leave the count unchanged.
- R4: In every encoder mode, an up step from the maximum count gives 0 and a down step from 0 gives the maximum count.
- R5: In modes 3'b100 and 3'b110, a rising index edge loads 0 if the direction is up and the maximum count if it is down. In modes 3'b101 and 3'b111 the index has no effect on the count.
- R6: Control bit 7 is a sticky error flag. It is set only in modes 3'b100 and 3'b110, when at a rising index edge the count differs from the value that edge loads. Writing the control word with bit 7 at 0 clears the flag. Writing 1 to bit 7 leaves it unchanged.
- R7: In mode 3'b001 the count changes by one every clock: up when control bit 5 is 1 and down when it is 0. Control bit 5 is writable only while the current mode is 3'b001.
- R8: In modes 3'b000, 3'b010 and 3'b011, phase and index activity leave the count unchanged.
- R9: When control bit 3 is 1, phases A and B are exchanged before decoding.
- R10: Control bit 5 reads the direction of the last encoder step (1 up, 0 down). Control bit 6 reads the synchronized index level. Control bits 2:0 hold the mode.
- R11: When control bit 4 is 1, `dir_oe_o` is 1 and `dir_o` follows the direction. When bit 4 is 0, both are 0.
- R12: A software write to the count (address 1) takes precedence over a same-cycle encoder step. A rising index edge in an index mode takes precedence over a same-cycle step, and the load value is chosen from that step's direction.
- R13: A sample where both phases change at once is treated as invalid and does not step the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_a_i | input | 1 | Phase A, asynchronous |
| enc_b_i | input | 1 | Phase B, asynchronous |
| enc_idx_i | input | 1 | Index pulse, asynchronous |
| reg_addr | input | 2 | Register select: 0 control, 1 count, 2 maximum count |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | CNT_W | Write data |
| reg_rdata | output | CNT_W | Read data for `reg_addr` |
| dir_o | output | 1 | Direction pin value |
| dir_oe_o | output | 1 | Direction pin drive enable |

## Verification
Two pairs of events can land in the same clock. The first pair is an encoder step and an index edge. The bench drives a phase A edge and the index rise on the same negative clock edge, so both pass through the synchronizer together. It then expects the index load value for the step's direction, and the error flag set from the count held before the step. The second pair is an encoder step and a software count write. The bench counts the synchronizer and decoder registers and holds the write strobe over the exact edge where the step would be applied. It then expects the written value and not that value plus one.

// File: rtl/qenc_pkg.sv
package qenc_pkg;

    typedef enum logic [2:0] {
        QM_OFF     = 3'b000,
        QM_TIMER   = 3'b001,
        QM_DIS_A   = 3'b010,
        QM_DIS_B   = 3'b011,
        QM_X2_IDX  = 3'b100,
        QM_X2_MAX  = 3'b101,
        QM_X4_IDX  = 3'b110,
        QM_X4_MAX  = 3'b111
    } qmode_e;

    // Control word layout, bit 7 down to bit 0
    typedef struct packed {
        logic   err;
        logic   idx_lvl;
        logic   dir;
        logic   dir_oe;
        logic   swap;
        qmode_e mode;
    } ctrl_view_t;

    localparam int CTRL_W = $bits(ctrl_view_t);
    localparam int ERR_BIT = 7;
    localparam int DIR_BIT = 5;

    typedef struct packed {
        logic step;
        logic up;
        logic idx_rise;
    } dec_ev_t;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_CNT  = 2'd1;
    localparam logic [1:0] ADDR_MAX  = 2'd2;

    function automatic logic is_enc(qmode_e m);
        return m[2];
    endfunction

    function automatic logic is_x4(qmode_e m);
        return m[2] & m[1];
    endfunction

    function automatic logic is_idx_mode(qmode_e m);
        return m[2] & ~m[0];
    endfunction

endpackage

// File: rtl/qenc_sync.sv
module qenc_sync #(
    parameter int WIDTH = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= '0;
            else     chain <= {chain[STAGES-2:0], d_i[g]};
        end
        assign q_o[g] = chain[STAGES-1];
    end
endmodule

// File: rtl/qenc_decode.sv
module qenc_decode
    import qenc_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    a_i,
    input  logic    b_i,
    input  logic    idx_i,
    input  logic    x4_i,
    output dec_ev_t ev_o
);
    logic pa, pb, pidx;
    logic da, db;

    always_ff @(posedge clk) begin
        if (rst) begin
            pa   <= 1'b0;
            pb   <= 1'b0;
            pidx <= 1'b0;
        end else begin
            pa   <= a_i;
            pb   <= b_i;
            pidx <= idx_i;
        end
    end

    assign da = a_i ^ pa;
    assign db = b_i ^ pb;

    always_comb begin
        ev_o.idx_rise = idx_i & ~pidx;
        if (x4_i) begin
            ev_o.step = da ^ db;
            ev_o.up   = a_i ^ pb;
        end else begin
            ev_o.step = da & ~db;
            ev_o.up   = a_i ^ b_i;
        end
    end

    // R13: a double change never yields a step
    a_r13_no_double_step: assert property (@(posedge clk) disable iff (rst)
        (da && db) |-> !ev_o.step);

    // R3: in x2 decoding a step needs a phase A edge
    a_r3_x2_a_only: assert property (@(posedge clk) disable iff (rst)
        (!x4_i && !da) |-> !ev_o.step);
endmodule

// File: rtl/qenc_poscnt.sv
module qenc_poscnt
    import qenc_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  qmode_e       mode_i,
    input  dec_ev_t      ev_i,
    input  logic [W-1:0] max_i,
    input  logic         cnt_we_i,
    input  logic [W-1:0] cnt_wdata_i,
    input  logic         dir_we_i,
    input  logic         dir_wdata_i,
    input  logic         err_clr_i,
    output logic [W-1:0] cnt_o,
    output logic         dir_o,
    output logic         err_o
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] cnt_n, tgt;
    logic         dir_n, err_n, enc, idxm, step_dir, timer;

    assign enc      = is_enc(mode_i);
    assign idxm     = is_idx_mode(mode_i);
    assign timer    = (mode_i == QM_TIMER);
    assign step_dir = ev_i.step ? ev_i.up : dir_o;
    assign tgt      = step_dir ? '0 : max_i;

    always_comb begin
        cnt_n = cnt_o;
        dir_n = dir_o;
        err_n = err_o & ~err_clr_i;
        if (cnt_we_i) begin
            cnt_n = cnt_wdata_i;
        end else if (timer) begin
            cnt_n = dir_o ? cnt_o + ONE : cnt_o - ONE;
        end else if (enc) begin
            if (idxm && ev_i.idx_rise)
                cnt_n = tgt;
            else if (ev_i.step && ev_i.up)
                cnt_n = (cnt_o == max_i) ? '0 : cnt_o + ONE;
            else if (ev_i.step)
                cnt_n = (cnt_o == '0) ? max_i : cnt_o - ONE;
        end
        if (enc && ev_i.step)
            dir_n = ev_i.up;
        else if (timer && dir_we_i)
            dir_n = dir_wdata_i;
        if (idxm && ev_i.idx_rise && (cnt_o != tgt))
            err_n = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_o <= '0;
            dir_o <= 1'b0;
            err_o <= 1'b0;
        end else begin
            cnt_o <= cnt_n;
            dir_o <= dir_n;
            err_o <= err_n;
        end
    end

    // R8: disabled modes hold the count
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        (!enc && !timer && !cnt_we_i) |=> (cnt_o == $past(cnt_o)));

    // R6: the error flag cannot rise outside index modes
    a_r6_err_idx_only: assert property (@(posedge clk) disable iff (rst)
        (!err_o && !idxm) |=> !err_o);

    // R10: direction follows the last encoder step
    a_r10_dir_follow: assert property (@(posedge clk) disable iff (rst)
        (enc && ev_i.step) |=> (dir_o == $past(ev_i.up)));

    // R4: up step at the maximum wraps to zero in match modes
    a_r4_wrap_up: assert property (@(posedge clk) disable iff (rst)
        (enc && !idxm && ev_i.step && ev_i.up && cnt_o == max_i && !cnt_we_i)
        |=> (cnt_o == '0));

    // R7: the timer moves every clock
    a_r7_timer_moves: assert property (@(posedge clk) disable iff (rst)
        (timer && !cnt_we_i) |=> (cnt_o != $past(cnt_o)));
endmodule

// File: rtl/qenc_counter.sv
module qenc_counter
    import qenc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enc_a_i,
    input  logic             enc_b_i,
    input  logic             enc_idx_i,
    input  logic [1:0]       reg_addr,
    input  logic             reg_we,
    input  logic [CNT_W-1:0] reg_wdata,
    output logic [CNT_W-1:0] reg_rdata,
    output logic             dir_o,
    output logic             dir_oe_o
);
    localparam int PAD_W = CNT_W - CTRL_W;

    qmode_e          mode_q;
    logic            swap_q, oe_q;
    logic [CNT_W-1:0] max_q, cnt;
    logic [2:0]      sync_q;
    logic            s_a, s_b, s_idx, dir, err;
    logic            ctrl_we;
    dec_ev_t         ev;
    ctrl_view_t      view;

    assign ctrl_we = reg_we && (reg_addr == ADDR_CTRL);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= QM_OFF;
            swap_q <= 1'b0;
            oe_q   <= 1'b0;
            max_q  <= '0;
        end else begin
            if (ctrl_we) begin
                mode_q <= qmode_e'(reg_wdata[2:0]);
                swap_q <= reg_wdata[3];
                oe_q   <= reg_wdata[4];
            end
            if (reg_we && reg_addr == ADDR_MAX)
                max_q <= reg_wdata;
        end
    end

    qenc_sync #(.WIDTH(3), .STAGES(2)) i_sync (
        .clk (clk),
        .rst (rst),
        .d_i ({enc_idx_i, enc_b_i, enc_a_i}),
        .q_o (sync_q)
    );

    assign s_a   = swap_q ? sync_q[1] : sync_q[0];
    assign s_b   = swap_q ? sync_q[0] : sync_q[1];
    assign s_idx = sync_q[2];

    qenc_decode i_dec (
        .clk   (clk),
        .rst   (rst),
        .a_i   (s_a),
        .b_i   (s_b),
        .idx_i (s_idx),
        .x4_i  (is_x4(mode_q)),
        .ev_o  (ev)
    );

    qenc_poscnt #(.W(CNT_W)) i_cnt (
        .clk         (clk),
        .rst         (rst),
        .mode_i      (mode_q),
        .ev_i        (ev),
        .max_i       (max_q),
        .cnt_we_i    (reg_we && reg_addr == ADDR_CNT),
        .cnt_wdata_i (reg_wdata),
        .dir_we_i    (ctrl_we),
        .dir_wdata_i (reg_wdata[DIR_BIT]),
        .err_clr_i   (ctrl_we && !reg_wdata[ERR_BIT]),
        .cnt_o       (cnt),
        .dir_o       (dir),
        .err_o       (err)
    );

    always_comb begin
        view.err     = err;
        view.idx_lvl = s_idx;
        view.dir     = dir;
        view.dir_oe  = oe_q;
        view.swap    = swap_q;
        view.mode    = mode_q;
        case (reg_addr)
            ADDR_CTRL: reg_rdata = {{PAD_W{1'b0}}, view};
            ADDR_CNT:  reg_rdata = cnt;
            ADDR_MAX:  reg_rdata = max_q;
            default:   reg_rdata = '0;
        endcase
    end

    assign dir_oe_o = oe_q;
    assign dir_o    = oe_q & dir;

    // R11: the pin is quiet while its drive is disabled
    a_r11_pin_quiet: assert property (@(posedge clk) disable iff (rst)
        !dir_oe_o |-> !dir_o);

    // R7: direction bit is frozen outside timer mode
    a_r7_dir_locked: assert property (@(posedge clk) disable iff (rst)
        (mode_q != QM_TIMER && !is_enc(mode_q)) |=> (dir == $past(dir)));
endmodule

// File: tb/test_qenc_counter.sv
module test_qenc_counter;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pa = 1'b0, pb = 1'b0, pidx = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic        reg_we = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        dir_o, dir_oe_o;
    int          checks = 0, errors = 0;
    logic        done = 1'b0;

    always #4 clk = ~clk;

    qenc_counter i_qenc_counter (
        .clk(clk), .rst(rst), .enc_a_i(pa), .enc_b_i(pb), .enc_idx_i(pidx),
        .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .dir_o(dir_o), .dir_oe_o(dir_oe_o)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic pins(input logic a, input logic b);
        @(negedge clk);
        pa = a; pb = b;
        repeat (4) @(negedge clk);
    endtask

    task automatic index_to(input logic v);
        @(negedge clk);
        pidx = v;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [15:0] v;
        rd(2'd0, v); chk("R1 ctrl", v, 16'h0);
        rd(2'd1, v); chk("R1 count", v, 16'h0);
        rd(2'd2, v); chk("R1 max", v, 16'h0);
        chk("R1 pins", {14'd0, dir_o, dir_oe_o}, 16'h0);
    endtask

    task automatic t_x4();
        logic [15:0] v;
        wr(2'd2, 16'd100); wr(2'd1, 16'd0); wr(2'd0, 16'h0007);
        pins(1, 0); pins(1, 1); pins(0, 1); pins(0, 0);
        rd(2'd1, v); chk("R2 x4 up four edges", v, 16'd4);
        rd(2'd0, v); chk("R10 dir up", {15'd0, v[5]}, 16'd1);
        chk("R10 mode readback", {13'd0, v[2:0]}, 16'd7);
        pins(0, 1); pins(1, 1);
        rd(2'd1, v); chk("R2 x4 down two edges", v, 16'd2);
        rd(2'd0, v); chk("R10 dir down", {15'd0, v[5]}, 16'd0);
    endtask

    task automatic t_x2();
        logic [15:0] v;
        wr(2'd0, 16'h0005); wr(2'd1, 16'd0);
        pins(0, 1);
        rd(2'd1, v); chk("R3 x2 A edge", v, 16'd1);
        pins(0, 0);
        rd(2'd1, v); chk("R3 x2 B edge ignored", v, 16'd1);
        pins(1, 0); pins(1, 1);
        rd(2'd1, v); chk("R3 x2 full cycle", v, 16'd2);
    endtask

    task automatic t_match();
        logic [15:0] v;
        wr(2'd0, 16'h0007); wr(2'd2, 16'd5); wr(2'd1, 16'd5);
        pins(0, 1);
        rd(2'd1, v); chk("R4 up from max", v, 16'd0);
        pins(1, 1);
        rd(2'd1, v); chk("R4 down from zero", v, 16'd5);
    endtask

    task automatic t_index();
        logic [15:0] v;
        wr(2'd0, 16'h0006); wr(2'd2, 16'd9); wr(2'd1, 16'd0);
        index_to(1);
        rd(2'd1, v); chk("R5 index load max when down", v, 16'd9);
        rd(2'd0, v); chk("R6 err set and R10 index level", {14'd0, v[7:6]}, 16'd3);
        index_to(0);
        pins(0, 1);
        rd(2'd1, v); chk("R4 wrap in index mode", v, 16'd0);
        rd(2'd0, v); chk("R6 err sticky", {15'd0, v[7]}, 16'd1);
        wr(2'd0, 16'h0086);
        rd(2'd0, v); chk("R6 writing one keeps err", {15'd0, v[7]}, 16'd1);
        wr(2'd0, 16'h0006);
        rd(2'd0, v); chk("R6 err cleared", {15'd0, v[7]}, 16'd0);
        index_to(1);
        rd(2'd1, v); chk("R5 index load zero when up", v, 16'd0);
        rd(2'd0, v); chk("R6 no err at boundary", {15'd0, v[7]}, 16'd0);
        index_to(0);
        wr(2'd0, 16'h0007); wr(2'd1, 16'd3);
        index_to(1);
        rd(2'd1, v); chk("R5 index ignored in match mode", v, 16'd3);
        rd(2'd0, v); chk("R6 no err in match mode", {15'd0, v[7]}, 16'd0);
        index_to(0);
    endtask

    task automatic t_same_cycle();
        logic [15:0] v;
        wr(2'd0, 16'h0006); wr(2'd2, 16'd9); wr(2'd1, 16'd4);
        @(negedge clk);
        pa = 1'b1; pb = 1'b1; pidx = 1'b1;
        repeat (4) @(negedge clk);
        rd(2'd1, v); chk("R12 index beats step", v, 16'd9);
        rd(2'd0, v); chk("R12 err and dir from step", {14'd0, v[7], v[5]}, 16'd2);
        index_to(0);
        wr(2'd0, 16'h0007); wr(2'd2, 16'd100); wr(2'd1, 16'd20);
        @(negedge clk);
        pa = 1'b0;
        @(negedge clk);
        @(negedge clk);
        reg_addr = 2'd1; reg_wdata = 16'd50; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
        repeat (3) @(negedge clk);
        rd(2'd1, v); chk("R12 write beats step", v, 16'd50);
    endtask

    task automatic t_swap();
        logic [15:0] v;
        wr(2'd0, 16'h000F); wr(2'd1, 16'd10);
        pins(1, 1);
        rd(2'd1, v); chk("R9 swapped step up", v, 16'd11);
        pins(1, 0);
        rd(2'd1, v); chk("R9 swapped second step up", v, 16'd12);
    endtask

    task automatic t_illegal();
        logic [15:0] v;
        wr(2'd0, 16'h0007); wr(2'd1, 16'd30);
        pins(0, 1);
        rd(2'd1, v); chk("R13 double change ignored", v, 16'd30);
    endtask

    task automatic t_dir_pin();
        logic [15:0] v;
        wr(2'd0, 16'h0017);
        pins(0, 0);
        chk("R11 pin up", {14'd0, dir_o, dir_oe_o}, 16'd3);
        pins(0, 1);
        chk("R11 pin down", {14'd0, dir_o, dir_oe_o}, 16'd1);
        wr(2'd0, 16'h0007);
        pins(0, 0);
        chk("R11 pin disabled", {14'd0, dir_o, dir_oe_o}, 16'd0);
        rd(2'd0, v); chk("R10 dir still tracked", {15'd0, v[5]}, 16'd1);
    endtask

    task automatic t_disabled();
        logic [15:0] v;
        for (int m = 0; m < 4; m++) begin
            if (m == 1) continue;
            wr(2'd0, 16'(m)); wr(2'd1, 16'd7);
            pins(~pa, pb);
            index_to(1); index_to(0);
            rd(2'd1, v); chk($sformatf("R8 hold in mode %0d", m), v, 16'd7);
        end
    endtask

    task automatic t_timer();
        logic [15:0] v1, v2;
        wr(2'd0, 16'h0001); wr(2'd0, 16'h0021);
        rd(2'd1, v1);
        repeat (5) @(negedge clk);
        rd(2'd1, v2); chk("R7 timer up", v2 - v1, 16'd5);
        wr(2'd0, 16'h0001);
        rd(2'd1, v1);
        repeat (5) @(negedge clk);
        rd(2'd1, v2); chk("R7 timer down", v1 - v2, 16'd5);
        wr(2'd0, 16'h0007); wr(2'd0, 16'h0027);
        rd(2'd0, v1); chk("R7 dir write ignored in encoder mode", {15'd0, v1[5]}, 16'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_x4();
        t_x2();
        t_match();
        t_index();
        t_same_cycle();
        t_swap();
        t_illegal();
        t_dir_pin();
        t_disabled();
        t_timer();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule